// File: doc/BRIEF.md
# Charge Status Pin Encoder

This block decides how a single open-drain status pin of a battery charger is driven. It takes five condition flags from the charger: charging active, charge current under the end-of-charge threshold, input current limit active, temperature fault and bad-battery fault. From these it produces a pull-down enable. In the steady states the pin is either held low for the whole time or left released.

When a fault is present, the pin switches on a fast carrier. The carrier period is made of 16 slots, and each slot is one pulse of an external tick enable that runs at 16 times the carrier rate. The fraction of each period spent pulled low alternates between a small value and a large value. This alternation is slow, so an LED on the pin blinks where a person can see it. A microcontroller can tell the fault type from the duty value alone, and each fault has its own blink rate and its own pair of duty values.

The block also has a debug output that copies the resulting pin level. Comparators, analog sensing and the pad driver belong to other blocks.

Top module: `chg_status_enc`

## Requirements
- R1: With charging asserted, the threshold flag low and no fault, pull_dn is 1 in the cycle after those inputs are sampled, and stays 1 while they hold.
- R2: With charging asserted, the threshold flag high, current limit low and no fault, pull_dn is 0 in the cycle after those inputs are sampled.
- R3: While current limit is asserted, the threshold flag is ignored: with charging asserted and no fault, pull_dn is 1 whatever the threshold flag is.
- R4: With charging low and no fault, pull_dn is 0.
- R5: While a fault is active, each carrier period lasts 16 tick pulses, numbered slot 0 to 15 from the start of the period. pull_dn is 1 in slots below the current duty count and 0 in the remaining slots.
- R6: A temperature fault uses a duty count of 1 in the low half and 15 in the high half. The half changes after every TEMP_HALF complete carrier periods. Each fault starts in the low half.
- R7: A bad-battery fault uses a duty count of 2 in the low half and 14 in the high half. The half changes after every BATT_HALF complete carrier periods.
- R8: When both faults are asserted, the temperature fault encoding is produced.
- R9: A change in the active fault (none, temperature, bad battery) restarts the pattern at slot 0 of a new carrier period, in the low half, with the period count cleared.
- R10: While rst_n is low, and until the reset synchronizer releases it, pull_dn is 0. Every counter restarts from zero afterwards.
- R11: In a cycle with tick low, the fault pattern does not advance, so pull_dn keeps its value.
- R12: pin_dbg is the pin level the output produces: 0 when pulled down and 1 when released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Slot enable, one pulse per sixteenth of a carrier period |
| charging | input | 1 | Charger is delivering current |
| below_end | input | 1 | Charge current is under the end-of-charge threshold |
| ilim | input | 1 | Input current limit is active |
| temp_fault | input | 1 | Battery temperature out of range |
| bad_batt | input | 1 | Battery did not respond to charging |
| pull_dn | output | 1 | Open-drain pull-down enable for the status pin |
| pin_dbg | output | 1 | Debug copy of the resulting pin level |

## Verification
The bench goes after the points where the pattern restarts. These are a switch between fault types in the middle of a carrier period, and the change when both faults are asserted or released together. A design that kept the old slot count at such a point would give a first period that is too short or too long, and a design that kept the old blink half would start in the high duty. The bench drives tick at random to catch slot or period counters that advance without an enable, because that would shift every later edge. It also drives the threshold flag under current limit to catch a false release, and it checks the carrier wrap and the half toggle at both fault rates, because an off-by-one error in either counter changes the blink period.

// File: rtl/chg_status_pkg.sv
package chg_status_pkg;

  typedef enum logic [1:0] {
    F_NONE = 2'd0,
    F_TEMP = 2'd1,
    F_BATT = 2'd2
  } fault_t;

endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s = sync_q[STAGES-1];

endmodule

// File: rtl/chg_mode_sel.sv
module chg_mode_sel
  import chg_status_pkg::*;
(
  input  logic   charging,
  input  logic   below_end,
  input  logic   ilim,
  input  logic   temp_fault,
  input  logic   bad_batt,
  output fault_t req_fault,
  output logic   steady_low
);

  always_comb begin
    if (temp_fault) begin
      req_fault = F_TEMP;
    end else if (bad_batt) begin
      req_fault = F_BATT;
    end else begin
      req_fault = F_NONE;
    end
    // the end threshold only counts when the input has headroom
    steady_low = charging & (ilim | ~below_end);
  end

endmodule

// File: rtl/chg_fault_timer.sv
module chg_fault_timer
  import chg_status_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int TEMP_HALF = 11667,
  parameter int BATT_HALF = 2869,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int HALF_MAX = (TEMP_HALF > BATT_HALF) ? TEMP_HALF : BATT_HALF,
  localparam int PER_W    = $clog2(HALF_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  fault_t            req_fault,
  output fault_t            fault_nx,
  output logic [SLOT_W-1:0] slot_nx,
  output logic              hi_nx
);

  fault_t              fault_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [PER_W-1:0]    per_q, per_nx, per_last;
  logic                hi_q;
  logic                restart, advance, upd_en;

  assign per_last = (fault_q == F_TEMP) ? PER_W'(TEMP_HALF - 1) : PER_W'(BATT_HALF - 1);
  assign restart  = (req_fault != fault_q);
  assign advance  = (fault_q != F_NONE) & tick;
  assign upd_en   = restart | advance;

  always_comb begin
    fault_nx = fault_q;
    slot_nx  = slot_q;
    per_nx   = per_q;
    hi_nx    = hi_q;
    if (restart) begin
      fault_nx = req_fault;
      slot_nx  = '0;
      per_nx   = '0;
      hi_nx    = 1'b0;
    end else if (advance) begin
      if (slot_q == SLOT_W'(SLOTS - 1)) begin
        slot_nx = '0;
        if (per_q == per_last) begin
          per_nx = '0;
          hi_nx  = ~hi_q;
        end else begin
          per_nx = per_q + 1'b1;
        end
      end else begin
        slot_nx = slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= F_NONE;
      slot_q  <= '0;
      per_q   <= '0;
      hi_q    <= 1'b0;
    end else if (upd_en) begin
      fault_q <= fault_nx;
      slot_q  <= slot_nx;
      per_q   <= per_nx;
      hi_q    <= hi_nx;
    end
  end

endmodule

// File: rtl/chg_status_enc.sv
module chg_status_enc
  import chg_status_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int TEMP_HALF  = 11667,
  parameter int BATT_HALF  = 2869,
  parameter int TEMP_LO    = 1,
  parameter int TEMP_HI    = 15,
  parameter int BATT_LO    = 2,
  parameter int BATT_HI    = 14,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W    = $clog2(SLOTS),
  localparam int DUTY_W    = SLOT_W + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic charging,
  input  logic below_end,
  input  logic ilim,
  input  logic temp_fault,
  input  logic bad_batt,
  output logic pull_dn,
  output logic pin_dbg
);

  logic              rst_s;
  fault_t            req_fault, fault_nx;
  logic              steady_low;
  logic [SLOT_W-1:0] slot_nx;
  logic              hi_nx;
  logic [DUTY_W-1:0] duty;
  logic              pull_d, pull_q;

  chg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  chg_mode_sel u_sel (
    .charging   (charging),
    .below_end  (below_end),
    .ilim       (ilim),
    .temp_fault (temp_fault),
    .bad_batt   (bad_batt),
    .req_fault  (req_fault),
    .steady_low (steady_low)
  );

  chg_fault_timer #(
    .SLOTS     (SLOTS),
    .TEMP_HALF (TEMP_HALF),
    .BATT_HALF (BATT_HALF)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_s),
    .tick      (tick),
    .req_fault (req_fault),
    .fault_nx  (fault_nx),
    .slot_nx   (slot_nx),
    .hi_nx     (hi_nx)
  );

  always_comb begin
    case (fault_nx)
      F_TEMP:  duty = hi_nx ? DUTY_W'(TEMP_HI) : DUTY_W'(TEMP_LO);
      F_BATT:  duty = hi_nx ? DUTY_W'(BATT_HI) : DUTY_W'(BATT_LO);
      default: duty = '0;
    endcase
    if (fault_nx == F_NONE) begin
      pull_d = steady_low;
    end else begin
      pull_d = ({1'b0, slot_nx} < duty);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pull_q <= 1'b0;
    end else begin
      pull_q <= pull_d;
    end
  end

  assign pull_dn = pull_q;
  assign pin_dbg = ~pull_q;

endmodule

// File: rtl/chg_status_chk.sv
module chg_status_chk (
  input logic clk,
  input logic rst_s,
  input logic tick,
  input logic charging,
  input logic below_end,
  input logic ilim,
  input logic temp_fault,
  input logic bad_batt,
  input logic pull_dn
);

  logic no_fault;
  assign no_fault = !temp_fault && !bad_batt;

  assert_charge_low_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (charging && !below_end && no_fault) |=> pull_dn);

  assert_end_release_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (charging && below_end && !ilim && no_fault) |=> !pull_dn);

  assert_limit_hold_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (charging && ilim && no_fault) |=> pull_dn);

  assert_idle_release_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (!charging && no_fault) |=> !pull_dn);

  assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(rst_s) && temp_fault && $past(temp_fault) && !tick) |=> $stable(pull_dn));

endmodule

bind chg_status_enc chg_status_chk u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .tick       (tick),
  .charging   (charging),
  .below_end  (below_end),
  .ilim       (ilim),
  .temp_fault (temp_fault),
  .bad_batt   (bad_batt),
  .pull_dn    (pull_dn)
);

// File: tb/sim_chg_status_enc.sv
module sim_chg_status_enc;

  localparam int CLK_PERIOD = 10;
  localparam int TH = 3;
  localparam int BH = 2;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic charging = 1'b0;
  logic below_end = 1'b0;
  logic ilim = 1'b0;
  logic temp_fault = 1'b0;
  logic bad_batt = 1'b0;
  logic pull_dn, pin_dbg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit rnd_tick = 0;

  // reference model state
  int rcnt = 0;
  int mf = 0, ms = 0, mp = 0, mh = 0;
  bit exp_pull = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_status_enc #(.TEMP_HALF(TH), .BATT_HALF(BH)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .charging(charging),
    .below_end(below_end), .ilim(ilim), .temp_fault(temp_fault),
    .bad_batt(bad_batt), .pull_dn(pull_dn), .pin_dbg(pin_dbg)
  );

  always @(posedge clk) begin
    int req, lim, dty;
    if (!rst_n) begin
      rcnt = 0; mf = 0; ms = 0; mp = 0; mh = 0; exp_pull = 0;
    end else if (rcnt < 2) begin
      rcnt++; exp_pull = 0;
    end else begin
      req = temp_fault ? 1 : (bad_batt ? 2 : 0);
      if (req != mf) begin
        mf = req; ms = 0; mp = 0; mh = 0;
      end else if (mf != 0 && tick) begin
        ms++;
        if (ms == 16) begin
          ms = 0; mp++;
          lim = (mf == 1) ? TH : BH;
          if (mp == lim) begin mp = 0; mh ^= 1; end
        end
      end
      if (mf == 0) exp_pull = charging && (ilim || !below_end);
      else begin
        dty = (mf == 1) ? (mh ? 15 : 1) : (mh ? 14 : 2);
        exp_pull = (ms < dty);
      end
    end
  end

  task automatic chk(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(pull_dn, exp_pull, tag);
      chk(pin_dbg, !exp_pull, "R12");
      tick = rnd_tick ? 1'($urandom_range(0, 1)) : 1'b1;
    end
  endtask

  task automatic set_in(input logic c, input logic b, input logic l,
                        input logic t, input logic f);
    charging = c; below_end = b; ilim = l; temp_fault = t; bad_batt = f;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    // R10: reset state, including the synchronizer release window
    set_in(1, 0, 0, 0, 0);
    run(4, "R10");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(pull_dn, 1'b0, "R10");
    chk(pin_dbg, 1'b1, "R12");
    run(10, "R1");
    // R2: end of charge releases
    set_in(1, 1, 0, 0, 0); run(10, "R2");
    // R3: current limit masks the threshold
    set_in(1, 1, 1, 0, 0); run(10, "R3");
    set_in(1, 0, 1, 0, 0); run(5, "R3");
    // R4: idle
    set_in(0, 0, 0, 0, 0); run(8, "R4");
    set_in(0, 1, 1, 0, 0); run(8, "R4");
    // R5/R6: temperature fault, two full blink cycles
    set_in(1, 0, 0, 1, 0); run(16 * TH * 4 + 5, "R6");
    // R7: bad battery, via restart from temperature (R9)
    set_in(1, 0, 0, 0, 1); run(16 * BH * 4 + 7, "R7");
    // R8: both faults, temperature wins
    set_in(1, 0, 0, 1, 1); run(16 * TH * 2 + 3, "R8");
    // R9: switch mid-period
    set_in(1, 0, 0, 0, 1); run(23, "R9");
    set_in(1, 0, 0, 1, 0); run(37, "R9");
    set_in(1, 0, 0, 0, 1); run(9, "R9");
    set_in(1, 1, 0, 0, 0); run(6, "R9");
    set_in(1, 0, 0, 0, 1); run(40, "R9");
    // R11: sparse ticks
    rnd_tick = 1;
    set_in(0, 0, 0, 1, 0); run(400, "R11");
    set_in(0, 0, 0, 0, 1); run(300, "R11");
    rnd_tick = 0;
    // R5: back to steady after fault clears
    set_in(1, 0, 0, 0, 0); run(10, "R1");
    // R10: reset in the middle of a fault
    set_in(0, 0, 0, 1, 0); run(30, "R6");
    @(negedge clk); rst_n = 1'b0;
    run(3, "R10");
    @(negedge clk); rst_n = 1'b1;
    run(60, "R10");
    finish_run();
  end

endmodule